// File: doc/BRIEF.md
# Cascadable Four-Channel Countdown Timer Group

The block holds four countdown timers behind one 32-bit register port. A shared prescaler turns pulses on the timer-clock enable input into count ticks. Each timer counts down once per tick. When it passes zero it reloads from its base value and sends a one-cycle pulse on its interrupt line. A set inhibit bit in the base register halts the timer. Software starts a timer by clearing that bit, and the timer then keeps firing periodically until the bit is set again.

A group control register holds three settings: the prescale ratio, a chain bit for each pair of neighbouring timers, and a roll-over bit for each pair. When a pair is chained, the lower timer works as the fast 32-bit digit and the upper timer counts how many full wraps remain. This gives a period of about 2^63 ticks. The pair's interrupt comes from the upper timer, and the upper timer's inhibit bit controls the whole pair.

Each channel has a small state machine with three states. ST_HALT means the channel is inhibited and quiet. ST_RUN means it is counting. ST_FIRE is the one-cycle interrupt state. An expiry moves any state to ST_FIRE (transition EXPIRE). Leaving ST_FIRE goes to ST_RUN when the channel is still enabled (RESUME) or to ST_HALT when it is not (STOP). From ST_HALT, clearing the inhibit bit enters ST_RUN (START), and from ST_RUN, setting it enters ST_HALT (STOP). Each cycle the count datapath takes one of four commands: HOLD, DEC, WRAP or RELOAD.

Top module: `tmr_group`

## Requirements
- R1: After reset the following hold: the control register reads 0, every base register reads 0x8000_0000, every current count reads 0, and all interrupt lines are low.
- R2: Control bits 9:8 at byte address 0x100 set the prescaler. Values 0, 1, 2 and 3 give one tick every 8, 16, 32 and 64 pulses of `tclk_en`.
- R3: An unchained running timer decrements on each tick. On a tick where its count is zero it reloads base bits 30:0 and raises its interrupt for exactly one cycle, in the cycle after that tick. This gives a period of base+1 ticks.
- R4: While base bit 31 (inhibit) is set, a timer does not count and does not interrupt. Clearing the bit starts the timer. A reload leaves the bit unchanged.
- R5: A base write with bit 31 set also loads the current count with data bits 30:0. A base write with bit 31 clear leaves the count alone.
- R6: A write to the current count loads the written value, and this write takes priority over a tick in the same cycle.
- R7: Pair k is chained only when control bit k and control bit 24+k are both set. Pair 0 is timers 0 and 1, pair 1 is timers 1 and 2, and pair 2 is timers 2 and 3. If two active pairs would share a timer, the lower-numbered pair wins and the other pair works as single timers.
- R8: In a chained pair, on each tick the low timer decrements. The exception is when the low count is 0 or 1 and the high count is nonzero. In that case the low count becomes (low + 0xFFFF_FFFE) mod 2^32 and the high count decrements. As a result, high×0xFFFF_FFFF + low drops by one per tick.
- R9: A chained pair expires on a tick where both counts are zero. The low timer then reloads its full 32-bit base, and the high timer reloads base bits 30:0. The interrupt comes only from the high timer, and the low timer's line stays quiet.
- R10: The inhibit bit of the high timer starts and stops a chained pair. The low timer's own bit 31 has no effect on counting.
- R11: Timer i occupies the 64-byte slot at 0x40×i, with its current count at +0x00 and its base at +0x10. Any other offset in a slot reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tclk_en | input | 1 | Timer-clock pulse, one per timer-clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-timer interrupt pulses |

## Verification
Single timers are tried at every prescale ratio. The runs with different ratios and the runs with different base values test tick generation separately from the reload period. Chained pairs are started from three states: low above one, low at one, and low at zero with the high count nonzero. These three starts tell the ordinary decrement apart from both wrap cases and from expiry. Patterns that set a chain bit without its roll-over bit, or that set two overlapping pairs, show which timers stay single. Writes while a timer is halted and writes to unused offsets show that the state is untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_DEC,
        CMD_WRAP,
        CMD_RELOAD
    } tmr_cmd_e;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_RUN,
        ST_FIRE
    } tmr_state_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W    = 2,
    parameter int BASE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tclk_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int PW      = $clog2(MAX_DIV);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    // Limit is the last pulse index of the selected ratio.
    assign lim  = PW'((BASE_DIV << sel) - 1);
    assign tick = tclk_en && (pcnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else if (tclk_en) begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_cmd_e      cmd_i,
    input  logic          fire_i,
    input  logic          run_i,
    input  logic          wide_i,
    input  logic          cnt_we_i,
    input  logic          base_we_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] base_o,
    output logic          irq_o
);
    localparam logic [CW-1:0] INH_BIT  = {1'b1, {(CW-1){1'b0}}};
    localparam logic [CW-1:0] WRAP_ADD = {{(CW-1){1'b1}}, 1'b0};

    tmr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= INH_BIT;
        end else if (base_we_i) begin
            base_o <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (cnt_we_i) begin
            cnt_o <= wdata_i;
        end else if (base_we_i && wdata_i[CW-1]) begin
            cnt_o <= {1'b0, wdata_i[CW-2:0]};
        end else begin
            unique case (cmd_i)
                CMD_HOLD:   cnt_o <= cnt_o;
                CMD_DEC:    cnt_o <= cnt_o - 1'b1;
                CMD_WRAP:   cnt_o <= cnt_o + WRAP_ADD;
                CMD_RELOAD: cnt_o <= wide_i ? base_o : {1'b0, base_o[CW-2:0]};
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: state_d = fire_i ? ST_FIRE : (run_i ? ST_RUN : ST_HALT);
            ST_RUN:  state_d = fire_i ? ST_FIRE : (run_i ? ST_RUN : ST_HALT);
            ST_FIRE: state_d = fire_i ? ST_FIRE : (run_i ? ST_RUN : ST_HALT);
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 32,
    parameter int AW = $clog2(NT) + 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tclk_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic [NT-1:0] irq
);
    localparam int SLOT_SH   = 6;
    localparam int TW        = $clog2(NT);
    localparam int NP        = NT - 1;
    localparam int SEL_W     = 2;
    localparam int DIV_LSB   = 8;
    localparam int CHAIN_LSB = 0;
    localparam int ROLL_LSB  = 24;
    localparam logic [AW-1:0]      CTRL_ADDR = AW'(NT << SLOT_SH);
    localparam logic [SLOT_SH-1:0] OFF_CNT   = 6'h00;
    localparam logic [SLOT_SH-1:0] OFF_BASE  = 6'h10;

    logic [SEL_W-1:0] sel_q;
    logic [NP-1:0]    chain_q, roll_q, pair_act;
    logic             tick;

    logic [NT-1:0][CW-1:0] cnt_v, base_v;
    logic [NT-1:0][CW-1:0] up_cnt, dn_cnt;
    logic [NT-1:0]         up_act, dn_act, up_inh;
    logic [NT-1:0]         cnt_we, base_we, fire, run;
    tmr_cmd_e              cmd [NT];

    logic                 in_tmr, ctrl_hit;
    logic [TW-1:0]        slot;
    logic [SLOT_SH-1:0]   off;

    assign slot     = addr[SLOT_SH +: TW];
    assign off      = addr[SLOT_SH-1:0];
    assign in_tmr   = (addr < CTRL_ADDR);
    assign ctrl_hit = (addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            chain_q <= '0;
            roll_q  <= '0;
        end else if (wr_en && ctrl_hit) begin
            sel_q   <= wdata[DIV_LSB +: SEL_W];
            chain_q <= wdata[CHAIN_LSB +: NP];
            roll_q  <= wdata[ROLL_LSB +: NP];
        end
    end

    // Lower pair claims a shared timer first.
    always_comb begin
        for (int k = 0; k < NP; k++) begin
            pair_act[k] = chain_q[k] && roll_q[k];
            if (k > 0 && pair_act[k-1]) pair_act[k] = 1'b0;
        end
    end

    tmr_prescale #(.SEL_W(SEL_W), .BASE_DIV(8)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tclk_en (tclk_en),
        .sel     (sel_q),
        .tick    (tick)
    );

    for (genvar g = 0; g < NT; g++) begin : g_ch
        if (g < NT - 1) begin : g_up
            assign up_act[g] = pair_act[g];
            assign up_inh[g] = base_v[g+1][CW-1];
            assign up_cnt[g] = cnt_v[g+1];
        end else begin : g_noup
            assign up_act[g] = 1'b0;
            assign up_inh[g] = 1'b1;
            assign up_cnt[g] = '0;
        end
        if (g > 0) begin : g_dn
            assign dn_act[g] = pair_act[g-1];
            assign dn_cnt[g] = cnt_v[g-1];
        end else begin : g_nodn
            assign dn_act[g] = 1'b0;
            assign dn_cnt[g] = '0;
        end

        assign cnt_we[g]  = wr_en && in_tmr && (slot == TW'(g)) && (off == OFF_CNT);
        assign base_we[g] = wr_en && in_tmr && (slot == TW'(g)) && (off == OFF_BASE);

        tmr_chan #(.CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_i     (cmd[g]),
            .fire_i    (fire[g]),
            .run_i     (run[g]),
            .wide_i    (up_act[g]),
            .cnt_we_i  (cnt_we[g]),
            .base_we_i (base_we[g]),
            .wdata_i   (wdata),
            .cnt_o     (cnt_v[g]),
            .base_o    (base_v[g]),
            .irq_o     (irq[g])
        );
    end

    // Per-channel count command: solo, chain low digit, or chain high digit.
    always_comb begin
        for (int i = 0; i < NT; i++) begin
            cmd[i]  = CMD_HOLD;
            fire[i] = 1'b0;
            if (up_act[i]) begin
                run[i] = !up_inh[i];
                if (tick && run[i]) begin
                    if (cnt_v[i] == '0 && up_cnt[i] == '0)  cmd[i] = CMD_RELOAD;
                    else if (cnt_v[i] <= CW'(1) && up_cnt[i] != '0) cmd[i] = CMD_WRAP;
                    else                                     cmd[i] = CMD_DEC;
                end
            end else if (dn_act[i]) begin
                run[i] = !base_v[i][CW-1];
                if (tick && run[i]) begin
                    if (cnt_v[i] == '0 && dn_cnt[i] == '0) begin
                        cmd[i]  = CMD_RELOAD;
                        fire[i] = 1'b1;
                    end else if (dn_cnt[i] <= CW'(1) && cnt_v[i] != '0) begin
                        cmd[i] = CMD_DEC;
                    end
                end
            end else begin
                run[i] = !base_v[i][CW-1];
                if (tick && run[i]) begin
                    if (cnt_v[i] == '0) begin
                        cmd[i]  = CMD_RELOAD;
                        fire[i] = 1'b1;
                    end else begin
                        cmd[i] = CMD_DEC;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (ctrl_hit) begin
            rdata[DIV_LSB +: SEL_W] = sel_q;
            rdata[CHAIN_LSB +: NP]  = chain_q;
            rdata[ROLL_LSB +: NP]   = roll_q;
        end else if (in_tmr) begin
            if (off == OFF_CNT)       rdata = cnt_v[slot];
            else if (off == OFF_BASE) rdata = base_v[slot];
        end
    end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk #(
    parameter int NT = 4,
    parameter int CW = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  tick,
    input logic [NT-1:0]         irq,
    input logic [NT-1:0]         up_act,
    input logic [NT-1:0]         dn_act,
    input logic [NT-1:0][CW-1:0] cnt_v,
    input logic [NT-1:0][CW-1:0] base_v
);
    // R2: the smallest ratio still leaves idle cycles between ticks
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    for (genvar i = 0; i < NT; i++) begin : g_a
        a_r3_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i]);

        a_r4_halt_still: assert property (@(posedge clk) disable iff (!rst_n)
            (!up_act[i] && !dn_act[i] && base_v[i][CW-1] && !wr_en)
            |=> $stable(cnt_v[i]));

        a_r9_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (up_act[i] && $past(up_act[i])) |-> !irq[i]);
    end
endmodule

bind tmr_group tmr_group_chk #(.NT(NT), .CW(CW)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .tick   (tick),
    .irq    (irq),
    .up_act (up_act),
    .dn_act (dn_act),
    .cnt_v  (cnt_v),
    .base_v (base_v)
);

// File: tb/test_tmr_group.sv
`timescale 1ns/1ps
module test_tmr_group;
    localparam int AW = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    wire  [3:0]  irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_group i_tmr_group (
        .clk(clk), .rst_n(rst_n), .tclk_en(tclk_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference state
    logic [31:0] m_cnt [4];
    logic [31:0] m_base [4];
    logic [31:0] nc [4];
    logic [1:0]  m_sel;
    logic [2:0]  m_chain, m_roll;
    bit   [3:0]  m_irq, fr;
    bit   [2:0]  act;
    int          m_pc, lim, t, o;
    bit          tk, lowrole, highrole;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_base[i] = 32'h8000_0000;
            end
            m_sel = 0; m_chain = 0; m_roll = 0; m_irq = 0; m_pc = 0;
        end else begin
            lim = (8 << m_sel) - 1;
            tk  = tclk_en && (m_pc >= lim);
            act[0] = m_chain[0] && m_roll[0];
            act[1] = m_chain[1] && m_roll[1] && !act[0];
            act[2] = m_chain[2] && m_roll[2] && !act[1];
            fr = 0;
            for (int i = 0; i < 4; i++) nc[i] = m_cnt[i];
            for (int i = 0; i < 4; i++) begin
                lowrole  = (i < 3) && act[i];
                highrole = (i > 0) && act[i-1];
                if (!lowrole && !highrole && tk && !m_base[i][31]) begin
                    if (m_cnt[i] == 0) begin
                        nc[i] = {1'b0, m_base[i][30:0]}; fr[i] = 1;
                    end else nc[i] = m_cnt[i] - 1;
                end
            end
            for (int k = 0; k < 3; k++) begin
                if (act[k] && tk && !m_base[k+1][31]) begin
                    if (m_cnt[k] == 0 && m_cnt[k+1] == 0) begin
                        nc[k] = m_base[k];
                        nc[k+1] = {1'b0, m_base[k+1][30:0]};
                        fr[k+1] = 1;
                    end else if (m_cnt[k] <= 1 && m_cnt[k+1] != 0) begin
                        nc[k] = m_cnt[k] + 32'hFFFF_FFFE;
                        nc[k+1] = m_cnt[k+1] - 1;
                    end else nc[k] = m_cnt[k] - 1;
                end
            end
            if (wr_en) begin
                if (addr == 9'h100) begin
                    m_sel = wdata[9:8]; m_chain = wdata[2:0]; m_roll = wdata[26:24];
                end else if (addr < 9'h100) begin
                    t = int'(addr) / 64; o = int'(addr) % 64;
                    if (o == 0) nc[t] = wdata;
                    else if (o == 16) begin
                        m_base[t] = wdata;
                        if (wdata[31]) nc[t] = {1'b0, wdata[30:0]};
                    end
                end
            end
            m_pc = tk ? 0 : m_pc + (tclk_en ? 1 : 0);
            for (int i = 0; i < 4; i++) m_cnt[i] = nc[i];
            m_irq = fr;
        end
    end

    function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
        logic [31:0] r = 0;
        if (a == 9'h100) begin
            r[9:8] = m_sel; r[2:0] = m_chain; r[26:24] = m_roll;
        end else if (a < 9'h100) begin
            if (a % 64 == 0)       r = m_cnt[a / 64];
            else if (a % 64 == 16) r = m_base[a / 64];
        end
        return r;
    endfunction

    // R3 R9: interrupt lines against the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R3/R9 irq at %0t: actual=%b expected=%b", $time, irq, m_irq);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s read 0x%0h: actual=0x%08h expected=0x%08h", req, a, rdata, e);
        end
    endtask

    task automatic rd_mdl(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== model_rd(a)) begin
            errors++;
            $display("FAIL %s read 0x%0h: actual=0x%08h expected=0x%08h", req, a, rdata, model_rd(a));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_exp(9'h100, 32'h0, "R1");
        rd_exp(9'h010, 32'h8000_0000, "R1");
        rd_exp(9'h0D0, 32'h8000_0000, "R1");
        rd_exp(9'h0C0, 32'h0, "R1");
        rd_exp(9'h020, 32'h0, "R11");
        // R5 base write with inhibit loads the count, without does not
        wr(9'h0D0, 32'h8000_0003);
        rd_exp(9'h0C0, 32'h3, "R5");
        wr(9'h0D0, 32'h0000_0005);
        rd_exp(9'h0C0, 32'h3, "R5");
        // R3 periodic solo timer, R2 ratios
        tclk_en = 1'b1;
        repeat (200) @(negedge clk);
        rd_mdl(9'h0C0, "R3");
        wr(9'h100, 32'h0000_0100);
        repeat (300) @(negedge clk);
        rd_mdl(9'h0C0, "R2");
        wr(9'h100, 32'h0000_0300);
        repeat (600) @(negedge clk);
        rd_mdl(9'h0C0, "R2");
        wr(9'h100, 32'h0000_0200);
        repeat (300) @(negedge clk);
        wr(9'h100, 32'h0000_0000);
        // R6 count write
        wr(9'h0C0, 32'h0000_0000);
        rd_mdl(9'h0C0, "R6");
        repeat (100) @(negedge clk);
        // R4 inhibit halts and holds
        wr(9'h0D0, 32'h8000_0003);
        repeat (100) @(negedge clk);
        rd_exp(9'h0C0, 32'h3, "R4");
        // R11 unused offsets
        wr(9'h0E0, 32'hFFFF_FFFF);
        wr(9'h0F0, 32'hFFFF_FFFF);
        rd_exp(9'h0E0, 32'h0, "R11");
        rd_exp(9'h0C0, 32'h3, "R11");
        rd_exp(9'h0D0, 32'h8000_0003, "R11");
        // R7 chain bit without roll-over: timers 1 and 2 stay single
        wr(9'h100, 32'h0000_0002);
        wr(9'h050, 32'h8000_0002);
        wr(9'h050, 32'h0000_0002);
        wr(9'h090, 32'h8000_0004);
        wr(9'h090, 32'h0000_0004);
        repeat (200) @(negedge clk);
        rd_mdl(9'h040, "R7");
        wr(9'h050, 32'h8000_0003);
        wr(9'h090, 32'h8000_0000);
        // R9 R10 pair 1 chained, low carries inhibit bit
        wr(9'h100, 32'h0200_0002);
        rd_exp(9'h100, 32'h0200_0002, "R7");
        wr(9'h090, 32'h0000_0000);
        repeat (100) @(negedge clk);
        rd_mdl(9'h040, "R9");
        rd_mdl(9'h080, "R9");
        wr(9'h090, 32'h8000_0000);
        // R8 low 2, high 1 -> wrap through one
        wr(9'h040, 32'h0000_0002);
        wr(9'h090, 32'h8000_0001);
        rd_exp(9'h080, 32'h1, "R8");
        wr(9'h090, 32'h0000_0001);
        for (int n = 0; n < 6; n++) begin
            repeat (7) @(negedge clk);
            rd_mdl(9'h040, "R8");
            rd_mdl(9'h080, "R8");
        end
        wr(9'h090, 32'h8000_0002);
        rd_mdl(9'h040, "R10");
        // R8 low 0, high 2 -> wrap through zero
        wr(9'h040, 32'h0000_0000);
        wr(9'h090, 32'h0000_0002);
        repeat (30) @(negedge clk);
        rd_mdl(9'h040, "R8");
        rd_mdl(9'h080, "R8");
        wr(9'h090, 32'h8000_0000);
        // R7 overlapping pairs: pair 0 wins, timer 2 single
        wr(9'h100, 32'h0300_0003);
        wr(9'h090, 32'h8000_0002);
        wr(9'h090, 32'h0000_0002);
        wr(9'h000, 32'h0000_0001);
        wr(9'h050, 32'h8000_0000);
        wr(9'h050, 32'h0000_0000);
        repeat (200) @(negedge clk);
        rd_mdl(9'h000, "R7");
        rd_mdl(9'h040, "R7");
        rd_mdl(9'h080, "R7");
        finish_run();
    end
endmodule